// File: doc/BRIEF.md
# 10 Mb/s MII Receive Framer

This block sits between a 10 Mb/s line decoder and the MII receive port of a MAC. The decoder hands it one recovered bit at a time, each marked by a bit-valid strobe, and raises an end-of-frame pulse when the carrier ends. The framer looks for the alternating preamble and the closing `1,1` of the start-of-frame delimiter. From that point it fixes the nibble boundary and packs the body bits into nibbles, first bit in bit 0. It then presents them on RXD with RX_DV and CRS. Every output is updated only on a nibble-rate enable.

A small nibble queue separates the bit side from the nibble side. Two static controls shape the frame start and end. The first selects whether preamble nibbles are stripped or forwarded. The second selects whether CRS drops on its own at end of frame or falls together with RX_DV. A loopback control replaces the received stream with the transmit nibbles of the MAC. Bits left over after the last whole byte are either padded out to a nibble or cut off, depending on how many there are.

Top module: `mii10_rx_framer`

## Requirements
- R1: While `rst_n` is low, `rxd` is 0 and `rx_dv` and `crs` are low.
- R2: `rxd`, `rx_dv` and `crs` change only on a clock edge where `nib_en` is high. Whenever `rx_dv` is low outside loopback, `rxd` is 0.
- R3: A frame starts only when a bit pair `1,1` follows a run of at least `PRE_RUN` alternating bits. A shorter alternating run followed by `1,1` produces no `rx_dv`. The nibble boundary is set on the bit right after the delimiter.
- R4: Body bits are packed least significant bit first. The first body bit of each nibble appears on `rxd[0]`, and each byte appears as its low nibble followed by its high nibble.
- R5: With `pre_pass` = 0, `rx_dv` stays low for the whole preamble. The first two nibbles with `rx_dv` high are 4'h5 then 4'hD, and `crs` rises on the same update as `rx_dv`.
- R6: With `pre_pass` = 1, once the alternating run reaches `PRE_RUN`, nibbles of value 4'h5 are driven with `rx_dv` high. At least two 4'h5 nibbles come before 4'hD, and `crs` and `rx_dv` rise on the same update.
- R7: With `crs_align` = 0, `crs` falls on the first `nib_en` update after the cycle in which `eof` is sampled. Queued nibbles keep being delivered with `rx_dv` high.
- R8: With `crs_align` = 1, `crs` equals `rx_dv` on every update, so `crs` falls on the same update as `rx_dv`.
- R9: When 1 to 4 bits follow the last whole byte, exactly one more nibble is delivered. It holds those bits in its low positions, and every position not received reads 1.
- R10: When 5 to 7 bits follow the last whole byte, only the nibble formed by the first 4 of them is delivered and the rest are dropped. When 0 bits follow, nothing extra is delivered.
- R11: With `lpbk` = 1, each `nib_en` update copies `txd` to `rxd` and `tx_en` to both `rx_dv` and `crs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_en | input | 1 | Nibble-rate update enable for the MII outputs |
| bit_vld | input | 1 | Strobe marking a valid recovered bit on `bit_in` |
| bit_in | input | 1 | Recovered serial bit |
| eof | input | 1 | End-of-frame pulse from the line decoder |
| pre_pass | input | 1 | 1 forwards preamble nibbles, 0 strips them |
| crs_align | input | 1 | 1 makes `crs` fall together with `rx_dv` |
| lpbk | input | 1 | Loopback select |
| tx_en | input | 1 | MAC transmit enable, used in loopback |
| txd | input | 4 | MAC transmit nibble, used in loopback |
| rxd | output | 4 | Receive nibble |
| rx_dv | output | 1 | Receive data valid |
| crs | output | 1 | Carrier sense |

## Verification
A body nibble is queued on the edge that samples its fourth bit, and it reaches `rxd` on the next `nib_en` edge or later. For that reason the bench compares the ordered list of `rx_dv` nibbles per frame rather than fixed cycle positions. The end of `crs` is checked against an exact index. The bench notes how many nibble updates had been recorded one clock after the edge that sampled `eof`, and it requires `crs` to be high on the update just before that index and low on the update at it. Loopback results are read one full nibble update after `txd` is driven. Between updates, each sample taken 5 ns after a clock edge without `nib_en` must equal the previous sample.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam logic [3:0] NIB_PRE = 4'h5;
    localparam logic [3:0] NIB_SFD = 4'hD;

    typedef struct packed {
        logic [3:0] rxd;
        logic       dv;
        logic       crs;
    } mii_rx_t;
endpackage

// File: rtl/rxf_sfd_det.sv
// Preamble run counter and delimiter detector on the serial bit stream.
module rxf_sfd_det #(
    parameter int RUN_MIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic active,
    input  logic clr,
    output logic pre_ok,
    output logic sfd_hit
);
    localparam int RW = $clog2(RUN_MIN + 1);

    typedef struct packed {
        logic          last;
        logic [RW-1:0] run;
    } det_t;

    det_t det_d, det_q;

    assign sfd_hit = bit_vld && !active && !clr && bit_in && det_q.last
                     && (det_q.run >= RW'(RUN_MIN));
    assign pre_ok  = !active && (det_q.run >= RW'(RUN_MIN));

    always_comb begin
        det_d = det_q;
        if (clr) begin
            det_d = '0;
        end else if (bit_vld && !active) begin
            det_d.last = bit_in;
            if (sfd_hit) begin
                det_d = '0;
            end else if (bit_in != det_q.last) begin
                if (det_q.run < RW'(RUN_MIN)) det_d.run = det_q.run + 1'b1;
            end else begin
                det_d.run = RW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end
endmodule

// File: rtl/rxf_packer.sv
// Packs body bits LSB first into nibbles; pads or drops the tail at end of frame.
module rxf_packer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       active,
    input  logic       start,
    input  logic       eof,
    output logic       push,
    output logic [3:0] nib
);
    typedef struct packed {
        logic [3:0] sh;
        logic [2:0] cnt;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        push = 1'b0;
        nib  = pk_q.sh;
        if (eof) begin
            // 1..3 leftover bits in the first half of a byte: pad with ones
            if (active && !pk_q.cnt[2] && (pk_q.cnt[1:0] != 2'd0)) begin
                push = 1'b1;
                for (int i = 0; i < 4; i++) begin
                    if (i >= int'(pk_q.cnt[1:0])) nib[i] = 1'b1;
                end
            end
            pk_d = '0;
        end else if (start) begin
            pk_d = '0;
        end else if (bit_vld && active) begin
            pk_d.sh[pk_q.cnt[1:0]] = bit_in;
            pk_d.cnt = pk_q.cnt + 1'b1;
            if (pk_q.cnt[1:0] == 2'd3) begin
                push     = 1'b1;
                nib      = pk_d.sh;
                pk_d.sh  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end
endmodule

// File: rtl/rxf_nib_fifo.sv
// Small nibble queue with two ordered write ports; DEPTH must be a power of two.
module rxf_nib_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr0,
    input  logic [3:0] d0,
    input  logic       wr1,
    input  logic [3:0] d1,
    input  logic       rd,
    output logic       empty,
    output logic [3:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][3:0] mem;
        logic [AW-1:0]         wp;
        logic [AW-1:0]         rp;
        logic [LW-1:0]         lvl;
    } fq_t;

    fq_t fq_d, fq_q;

    assign empty = (fq_q.lvl == '0);
    assign head  = fq_q.mem[fq_q.rp];

    always_comb begin
        int used;
        fq_d = fq_q;
        used = int'(fq_q.lvl);
        if (wr0 && used < DEPTH) begin
            fq_d.mem[fq_d.wp] = d0;
            fq_d.wp = fq_d.wp + 1'b1;
            used++;
        end
        if (wr1 && used < DEPTH) begin
            fq_d.mem[fq_d.wp] = d1;
            fq_d.wp = fq_d.wp + 1'b1;
            used++;
        end
        if (rd && !empty) begin
            fq_d.rp = fq_q.rp + 1'b1;
            used--;
        end
        fq_d.lvl = LW'(used);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fq_q <= '0;
        else        fq_q <= fq_d;
    end
endmodule

// File: rtl/mii10_rx_framer.sv
module mii10_rx_framer
    import rxf_pkg::*;
#(
    parameter int PRE_RUN    = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_en,
    input  logic       bit_vld,
    input  logic       bit_in,
    input  logic       eof,
    input  logic       pre_pass,
    input  logic       crs_align,
    input  logic       lpbk,
    input  logic       tx_en,
    input  logic [3:0] txd,
    output logic [3:0] rxd,
    output logic       rx_dv,
    output logic       crs
);
    typedef struct packed {
        logic    carrier;
        logic    body;
        mii_rx_t o;
    } top_t;

    top_t st_d, st_q;

    logic       pre_ok, sfd_hit;
    logic       pk_push;
    logic [3:0] pk_nib;
    logic       f_empty, f_pop;
    logic [3:0] f_head;

    rxf_sfd_det #(.RUN_MIN(PRE_RUN)) u_det (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .active(st_q.body), .clr(eof), .pre_ok(pre_ok), .sfd_hit(sfd_hit)
    );

    rxf_packer u_pack (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .active(st_q.body), .start(sfd_hit), .eof(eof),
        .push(pk_push), .nib(pk_nib)
    );

    // The delimiter queues 5 then D in one cycle; body nibbles use port 0.
    rxf_nib_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr0(sfd_hit | pk_push), .d0(sfd_hit ? NIB_PRE : pk_nib),
        .wr1(sfd_hit), .d1(NIB_SFD),
        .rd(f_pop), .empty(f_empty), .head(f_head)
    );

    always_comb begin
        st_d  = st_q;
        f_pop = 1'b0;
        if (eof) begin
            st_d.carrier = 1'b0;
            st_d.body    = 1'b0;
        end else if (sfd_hit) begin
            st_d.carrier = 1'b1;
            st_d.body    = 1'b1;
        end else if (pre_ok) begin
            st_d.carrier = 1'b1;
        end

        if (nib_en) begin
            if (lpbk) begin
                st_d.o.rxd = txd;
                st_d.o.dv  = tx_en;
                st_d.o.crs = tx_en;
            end else begin
                if (!f_empty) begin
                    f_pop      = 1'b1;
                    st_d.o.rxd = f_head;
                    st_d.o.dv  = 1'b1;
                end else if (pre_pass && st_q.carrier && !st_q.body) begin
                    st_d.o.rxd = NIB_PRE;
                    st_d.o.dv  = 1'b1;
                end else begin
                    st_d.o.rxd = '0;
                    st_d.o.dv  = 1'b0;
                end
                st_d.o.crs = (pre_pass ? st_q.carrier : st_q.body)
                             | (crs_align & st_d.o.dv);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rxd   = st_q.o.rxd;
    assign rx_dv = st_q.o.dv;
    assign crs   = st_q.o.crs;
endmodule

// File: rtl/mii10_rx_framer_chk.sv
module mii10_rx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nib_en,
    input logic       lpbk,
    input logic       crs_align,
    input logic [3:0] rxd,
    input logic       rx_dv,
    input logic       crs
);
    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_idle_chk: assert (rxd == 4'd0 && !rx_dv && !crs);
        end
    end

    // R2
    hold_between_updates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_en |=> $stable({rxd, rx_dv, crs}));

    // R5
    first_nibble_five_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lpbk && $rose(rx_dv)) |-> (rxd == 4'h5));

    // R6
    crs_with_dv_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lpbk && $rose(rx_dv)) |-> crs);

    // R8
    aligned_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crs_align && !lpbk && $fell(crs)) |-> !rx_dv);
endmodule

bind mii10_rx_framer mii10_rx_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .lpbk(lpbk),
    .crs_align(crs_align), .rxd(rxd), .rx_dv(rx_dv), .crs(crs)
);

// File: tb/mii10_rx_framer_test.sv
module mii10_rx_framer_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       nib_en = 1'b0, bit_vld = 1'b0, bit_in = 1'b0, eof = 1'b0;
    logic       pre_pass = 1'b0, crs_align = 1'b0, lpbk = 1'b0, tx_en = 1'b0;
    logic [3:0] txd = 4'd0;
    logic [3:0] rxd;
    logic       rx_dv, crs;

    mii10_rx_framer uut (
        .clk(clk), .rst_n(rst_n), .nib_en(nib_en), .bit_vld(bit_vld),
        .bit_in(bit_in), .eof(eof), .pre_pass(pre_pass), .crs_align(crs_align),
        .lpbk(lpbk), .tx_en(tx_en), .txd(txd), .rxd(rxd), .rx_dv(rx_dv), .crs(crs)
    );

    typedef struct packed {
        logic       pp;
        logic       al;
        logic [3:0] nb;
        logic [2:0] dr;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 4'd3, 3'd0}, '{1'b0, 1'b1, 4'd2, 3'd1},
        '{1'b1, 1'b0, 4'd3, 3'd2}, '{1'b1, 1'b1, 4'd1, 3'd3},
        '{1'b0, 1'b0, 4'd2, 3'd4}, '{1'b1, 1'b0, 4'd2, 3'd5},
        '{1'b0, 1'b1, 4'd3, 3'd6}, '{1'b1, 1'b1, 4'd4, 3'd7}
    };

    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    bit   rec_on = 1'b0;
    int   scount = 0;
    logic hit_r;
    logic [5:0] prev = '0;
    logic [3:0] s_rxd [256];
    logic       s_dv  [256];
    logic       s_crs [256];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample 5 ns after each edge; record updates, verify holds otherwise (R2).
    always @(posedge clk) begin
        hit_r = nib_en;
        #5;
        if (rec_on && rst_n) begin
            if (hit_r) begin
                if (scount < 256) begin
                    s_rxd[scount] = rxd;
                    s_dv[scount]  = rx_dv;
                    s_crs[scount] = crs;
                end
                scount++;
            end else begin
                chk({rxd, rx_dv, crs} === prev, "R2 hold", int'({rxd, rx_dv, crs}), int'(prev));
            end
        end
        prev = {rxd, rx_dv, crs};
    end

    initial begin
        forever begin
            repeat (3) begin
                @(negedge clk);
                nib_en = 1'b0;
            end
            @(negedge clk);
            nib_en = 1'b1;
        end
    end

    task automatic send(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
    endtask

    task automatic finish_frame(output int eidx);
        @(negedge clk);
        bit_vld = 1'b0;
        eof     = 1'b1;
        @(negedge clk);
        eof  = 1'b0;
        eidx = scount;
        repeat (40) @(negedge clk);
        rec_on = 1'b0;
    endtask

    task automatic wait_updates(input int n);
        int c;
        c = scount;
        wait (scount >= c + n);
        @(negedge clk);
    endtask

    task automatic run_frame(input vec_t v, input int f);
        logic [3:0] ex [64];
        logic [3:0] ac [256];
        int elen, alen, k, off, eidx, first, last;
        logic [7:0] b, x;
        bit ok;
        string req;
        pre_pass  = v.pp;
        crs_align = v.al;
        scount    = 0;
        rec_on    = 1'b1;
        ex[0] = 4'h5;
        ex[1] = 4'hD;
        elen  = 2;
        repeat (16) begin
            send(1'b1);
            send(1'b0);
        end
        send(1'b1);
        send(1'b1);
        for (int i = 0; i < int'(v.nb); i++) begin
            b = 8'(f * 29 + i * 53 + 7);
            for (int j = 0; j < 8; j++) send(b[j]);
            ex[elen] = b[3:0];
            ex[elen+1] = b[7:4];
            elen += 2;
        end
        x = 8'(f * 71 + 90);
        for (int j = 0; j < int'(v.dr); j++) send(x[j]);
        if (v.dr != 0) begin
            ex[elen] = x[3:0];
            for (int j = 0; j < 4; j++) if (j >= int'(v.dr)) ex[elen][j] = 1'b1;
            elen++;
        end
        finish_frame(eidx);

        alen = 0;
        for (int s = 0; s < scount && s < 256; s++) begin
            if (s_dv[s]) begin
                ac[alen] = s_rxd[s];
                alen++;
            end
        end
        k = 0;
        while (k < alen && ac[k] == 4'h5) k++;
        off = (v.pp && k > 0) ? k - 1 : 0;

        // R5 strip start / R6 pass start
        req = v.pp ? "R6 start" : "R5 start";
        if (v.pp) chk(k >= 2 && alen > k && ac[k] == 4'hD, req, k, 2);
        else      chk(alen >= 2 && ac[0] == 4'h5 && ac[1] == 4'hD, req,
                      alen >= 2 ? int'({ac[0], ac[1]}) : -1, 8'h5D);

        // R3 alignment, R4 LSB-first body, R9/R10 dribble tail
        req = (v.dr == 0) ? "R3 R4 R10 body" : (v.dr <= 4) ? "R9 body" : "R10 body";
        ok = (alen - off == elen);
        for (int i = 0; i < elen && ok; i++) begin
            if (ac[off + i] !== ex[i]) begin
                ok = 1'b0;
                chk(1'b0, req, int'(ac[off + i]), int'(ex[i]));
            end
        end
        if (alen - off != elen) chk(1'b0, req, alen - off, elen);
        else if (ok) chk(1'b1, req, 0, 0);

        // R5/R6: crs and rx_dv rise on the same update
        first = -1;
        for (int s = scount - 1; s >= 0; s--) if (s_dv[s] || s_crs[s]) first = s;
        chk(first >= 0 && s_dv[first] && s_crs[first], v.pp ? "R6 rise" : "R5 rise",
            first >= 0 ? int'({s_dv[first], s_crs[first]}) : -1, 2'b11);

        if (v.al) begin
            ok = 1'b1;
            for (int s = 0; s < scount; s++) if (s_crs[s] !== s_dv[s]) ok = 1'b0;
            chk(ok, "R8 crs==dv", int'(ok), 1);
        end else begin
            chk(eidx > 0 && eidx < scount && s_crs[eidx-1] && !s_crs[eidx], "R7 crs fall",
                int'({s_crs[eidx-1], s_crs[eidx]}), 2'b10);
        end

        last = scount - 1;
        chk(!s_dv[last] && !s_crs[last] && s_rxd[last] == 4'd0, "R2 idle",
            int'({s_rxd[last], s_dv[last], s_crs[last]}), 0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int eidx;
        bit ok;
        #15;
        // R1
        chk(rxd == 4'd0 && !rx_dv && !crs, "R1 reset", int'({rxd, rx_dv, crs}), 0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(rxd == 4'd0 && !rx_dv && !crs, "R1 after reset", int'({rxd, rx_dv, crs}), 0);

        for (int f = 0; f < 8; f++) run_frame(VEC[f], f);

        // R3: short alternating run then 1,1 must not open a frame
        pre_pass = 1'b1;
        crs_align = 1'b0;
        scount = 0;
        rec_on = 1'b1;
        send(1'b1); send(1'b0); send(1'b1); send(1'b0); send(1'b1); send(1'b1);
        for (int j = 0; j < 12; j++) send(1'(j % 3));
        finish_frame(eidx);
        ok = 1'b1;
        for (int s = 0; s < scount; s++) if (s_dv[s] || s_crs[s]) ok = 1'b0;
        chk(ok, "R3 short preamble", int'(ok), 1);

        // R11 loopback
        rec_on = 1'b1;
        lpbk = 1'b1;
        txd = 4'hA;
        tx_en = 1'b1;
        wait_updates(2);
        chk(rxd == 4'hA && rx_dv && crs, "R11 loop on", int'({rxd, rx_dv, crs}), 6'b1010_11);
        txd = 4'h3;
        tx_en = 1'b0;
        wait_updates(2);
        chk(rxd == 4'h3 && !rx_dv && !crs, "R11 loop off", int'({rxd, rx_dv, crs}), 6'b0011_00);
        lpbk = 1'b0;
        wait_updates(2);
        chk(rxd == 4'd0 && !rx_dv && !crs, "R2 idle after loopback", int'({rxd, rx_dv, crs}), 0);
        rec_on = 1'b0;

        summary();
    end
endmodule